// File: doc/BRIEF.md
# Power-Manager Control Register Bank

This block is the register side of a power-management companion device that a host reaches over a two-wire serial bus. A bus front end, outside this block, turns bus traffic into three byte events: a start of a write transfer, a received byte, and a request for a byte to send. The block keeps a bank of 8-bit control registers for regulators, oscillator, detection, general-purpose lines and card-slot control. It also keeps an 8-bit register pointer that the host loads with the first byte of each write transfer.

Data bytes that follow go to the register under the pointer, and reads return that register. The pointer advances after every data byte in either direction, so the host can move a burst of bytes with one address. Every register keeps only its own writable bits. Two core-voltage registers saturate the written code. A few addresses return computed or constant values. A write that sets the power-off bit puts the whole bank back to its reset contents.

Top module: `pmr_regbank`

## Requirements
- R1: After reset the bank holds its defaults, among them oscillator control 0x01 (read as 0x81), detect control 0x09, line direction 0x07, debounce 0x05, core control at 0x02 equal to 0x0C, card control at 0x37 equal to 0xC0, and rd_data is 0x00.
- R2: The first wr_valid byte after start_wr loads the pointer. Each later wr_valid byte is written to the addressed register, and the pointer then advances by one.
- R3: Each rd_req places the addressed register's read value on rd_data from the next cycle on and advances the pointer by one, so consecutive requests return consecutive addresses.
- R4: Address 0x01 always reads 0x22, and writes to it have no effect.
- R5: Writes to 0x04 and 0x05 keep bits 4:0 of the data and saturate the result at 0x12.
- R6: Writes keep only the register's valid bits: direction (0x1D) bits 0x67, line outputs (0x1F) bits 0x07, detect (0x16) bits 0x7F, debounce (0x3A) bits 0x3F, oscillator (0x15) bits 0x07.
- R7: A read of oscillator control (0x15) returns the stored bits with bit 7 forced to 1.
- R8: A read of 0x1E returns in bits 2:0 gpio_in ORed with the output bits of the lines whose direction bit is 0; bits 7:3 read 0. The gpo port drives the output bits ANDed with the inverted direction bits.
- R9: A write of any value to the backup register (0x20) makes it read 0x0D.
- R10: A write to 0x14 with bit 0 set returns every register to its reset value. With bit 0 clear the write changes nothing. 0x14 reads 0x00.
- R11: Addresses without a register, including all addresses at 0x40 and above, read 0x00, and writes to them are dropped.
- R12: The pointer is 8 bits wide and advances from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | Pulse: a write transfer has started |
| wr_valid | input | 1 | Pulse: a byte has been received |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Pulse: the front end needs a byte to send |
| rd_data | output | 8 | Byte to send, registered on rd_req |
| gpio_in | input | 3 | Levels of the external general-purpose lines |
| gpo | output | 3 | Driven levels of the lines configured as outputs |

## Verification
The bench goes after the edges where a register bank is easily wrong. A clamp that compared the whole byte instead of bits 4:0 would store 0x12 for 0x31 rather than 0x11. A pointer that stopped or went wider at 0xFF would leave the write meant for 0x02 undone. A soft reset decoded from the whole byte instead of bit 0 would clear the bank on 0x02. The line-input read is checked with lines switched between input and output, because a design that used the direction bits the wrong way round would merge the output bits into the wrong lines. The backup register is written with 0x00 and 0xFF, since a plain masked store would read one of those values back instead of 0x0D.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam logic [7:0] A_REV    = 8'h01;
    localparam logic [7:0] A_CORE3  = 8'h04;
    localparam logic [7:0] A_CORE4  = 8'h05;
    localparam logic [7:0] A_OFF    = 8'h14;
    localparam logic [7:0] A_OSC    = 8'h15;
    localparam logic [7:0] A_DETECT = 8'h16;
    localparam logic [7:0] A_DIR    = 8'h1D;
    localparam logic [7:0] A_LINEIN = 8'h1E;
    localparam logic [7:0] A_LINEOUT= 8'h1F;
    localparam logic [7:0] A_BACKUP = 8'h20;
    localparam logic [7:0] A_DEBNC  = 8'h3A;

    localparam logic [7:0] REV_VALUE    = 8'h22;
    localparam logic [7:0] BACKUP_VALUE = 8'h0D;
    localparam logic [7:0] CORE_MAX     = 8'h12;

    // Default contents of each storage location.
    function automatic logic [7:0] reg_reset(input logic [7:0] a);
        case (a)
            8'h02: return 8'h0C;
            8'h03: return 8'h05;
            8'h04: return 8'h02;
            8'h05: return 8'h0C;
            8'h06: return 8'h03;
            8'h07: return 8'h33;
            8'h08: return 8'h03;
            8'h0A: return 8'h95;
            8'h0B: return 8'h7E;
            8'h0E: return 8'h03;
            8'h15: return 8'h01;
            8'h16: return 8'h09;
            8'h1D: return 8'h07;
            8'h36: return 8'h03;
            8'h37: return 8'hC0;
            8'h3A: return 8'h05;
            default: return 8'h00;
        endcase
    endfunction

    // Writable bits per location; zero means no storage there.
    function automatic logic [7:0] reg_mask(input logic [7:0] a);
        case (a)
            8'h02, 8'h03, 8'h0A, 8'h12, 8'h13,
            8'h32, 8'h34, 8'h37:               return 8'hFF;
            8'h04, 8'h05, 8'h33, 8'h35:        return 8'h1F;
            8'h06, 8'h0C, 8'h0D, 8'h0E,
            8'h0F, 8'h10, 8'h11:               return 8'h03;
            8'h07, 8'h3A:                      return 8'h3F;
            8'h08, 8'h09, 8'h15, 8'h1F:        return 8'h07;
            8'h0B, 8'h16, 8'h36:               return 8'h7F;
            8'h1D:                             return 8'h67;
            8'h20:                             return 8'h0F;
            8'h38:                             return 8'h0F;
            default:                           return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/pmr_wrfilter.sv
module pmr_wrfilter
    import pmr_pkg::*;
(
    input  logic [7:0] addr,
    input  logic [7:0] data,
    output logic       we,
    output logic [7:0] wval,
    output logic       soft_rst
);
    logic [7:0] low5;
    logic [7:0] msk;

    always_comb begin
        low5     = data & 8'h1F;
        msk      = reg_mask(addr);
        we       = (msk != 8'h00);
        soft_rst = (addr == A_OFF) && data[0];
        case (addr)
            A_CORE3, A_CORE4: wval = (low5 > CORE_MAX) ? CORE_MAX : low5;
            A_BACKUP:         wval = BACKUP_VALUE;
            default:          wval = data & msk;
        endcase
    end
endmodule

// File: rtl/pmr_rdmux.sv
module pmr_rdmux
    import pmr_pkg::*;
#(
    parameter int NREG = 64,
    parameter int NLINE = 3
) (
    input  logic [7:0]            addr,
    input  logic [NREG-1:0][7:0]  bank,
    input  logic [NLINE-1:0]      line_in,
    output logic [7:0]            value
);
    localparam int AW = $clog2(NREG);
    localparam logic [8:0] NREG_W = 9'(NREG);

    logic [NLINE-1:0] drv_bits;
    logic [7:0]       stored;
    logic             in_range;

    assign in_range = ({1'b0, addr} < NREG_W);
    assign stored   = in_range ? bank[addr[AW-1:0]] : 8'h00;
    assign drv_bits = bank[A_LINEOUT[AW-1:0]][NLINE-1:0] & ~bank[A_DIR[AW-1:0]][NLINE-1:0];

    always_comb begin
        case (addr)
            A_REV:    value = REV_VALUE;
            A_OSC:    value = stored | 8'h80;
            A_LINEIN: value = 8'((line_in | drv_bits));
            default:  value = stored;
        endcase
    end
endmodule

// File: rtl/pmr_regbank.sv
module pmr_regbank
    import pmr_pkg::*;
#(
    parameter int NREG  = 64,
    parameter int NLINE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             rd_req,
    output logic [7:0]       rd_data,
    input  logic [NLINE-1:0] gpio_in,
    output logic [NLINE-1:0] gpo
);
    localparam int AW = $clog2(NREG);
    localparam logic [8:0] NREG_W = 9'(NREG);

    typedef struct packed {
        logic [7:0]           ptr;
        logic                 first;
        logic [7:0]           rdata;
        logic [NREG-1:0][7:0] bank;
    } state_t;

    state_t st_d, st_q;

    logic       f_we, f_soft;
    logic [7:0] f_val, rd_val;
    logic       ptr_ok;

    assign ptr_ok = ({1'b0, st_q.ptr} < NREG_W);

    pmr_wrfilter u_wf (
        .addr     (st_q.ptr),
        .data     (wr_data),
        .we       (f_we),
        .wval     (f_val),
        .soft_rst (f_soft)
    );

    pmr_rdmux #(.NREG(NREG), .NLINE(NLINE)) u_rm (
        .addr    (st_q.ptr),
        .bank    (st_q.bank),
        .line_in (gpio_in),
        .value   (rd_val)
    );

    always_comb begin
        st_d = st_q;
        if (start_wr) begin
            st_d.first = 1'b1;
        end else if (wr_valid) begin
            if (st_q.first) begin
                st_d.ptr   = wr_data;
                st_d.first = 1'b0;
            end else begin
                if (f_soft) begin
                    for (int i = 0; i < NREG; i++) st_d.bank[i] = reg_reset(8'(i));
                end else if (f_we && ptr_ok) begin
                    st_d.bank[st_q.ptr[AW-1:0]] = f_val;
                end
                st_d.ptr = st_q.ptr + 8'd1;
            end
        end else if (rd_req) begin
            st_d.rdata = rd_val;
            st_d.ptr   = st_q.ptr + 8'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= 8'h00;
            st_q.first <= 1'b0;
            st_q.rdata <= 8'h00;
            for (int i = 0; i < NREG; i++) st_q.bank[i] <= reg_reset(8'(i));
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
    assign gpo     = st_q.bank[A_LINEOUT[AW-1:0]][NLINE-1:0] & ~st_q.bank[A_DIR[AW-1:0]][NLINE-1:0];

    logic rd_only, wr_data_ev;
    assign rd_only    = rd_req && !start_wr && !wr_valid;
    assign wr_data_ev = wr_valid && !start_wr && !st_q.first;

    // R4
    rev_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && st_q.ptr == A_REV |=> rd_data == REV_VALUE);

    // R3
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only |=> st_q.ptr == $past(st_q.ptr) + 8'd1);

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_ev |=> st_q.ptr == $past(st_q.ptr) + 8'd1);

    // R7
    osc_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && st_q.ptr == A_OSC |=> rd_data[7]);

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && !ptr_ok |=> rd_data == 8'h00);

    // R5
    core_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bank[A_CORE3[AW-1:0]] <= CORE_MAX && st_q.bank[A_CORE4[AW-1:0]] <= CORE_MAX);

    // R9
    backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bank[A_BACKUP[AW-1:0]] == 8'h00 || st_q.bank[A_BACKUP[AW-1:0]] == BACKUP_VALUE);

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_ev && st_q.ptr == A_OFF && wr_data[0]
        |=> st_q.bank[A_DETECT[AW-1:0]] == 8'h09 && st_q.bank[A_DIR[AW-1:0]] == 8'h07
            && st_q.bank[A_DEBNC[AW-1:0]] == 8'h05);
endmodule

// File: tb/pmr_regbank_test.sv
`timescale 1ns/1ps
module pmr_regbank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_wr = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_req = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] gpio_in = 3'b000;
    logic [2:0] gpo;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pmr_regbank uut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .gpio_in(gpio_in), .gpo(gpo)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_data = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic fetch(output logic [7:0] b);
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        b = rd_data;
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] v);
        pulse_start(); send(a); send(v);
    endtask

    task automatic get(input logic [7:0] a, output logic [7:0] v);
        pulse_start(); send(a); fetch(v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk("R8 gpo after reset", {5'b0, gpo}, 8'h00);
        get(8'h15, v); chk("R1 osc default", v, 8'h81);
        get(8'h16, v); chk("R1 detect default", v, 8'h09);
        get(8'h1D, v); chk("R1 dir default", v, 8'h07);
        get(8'h3A, v); chk("R1 debounce default", v, 8'h05);
        get(8'h37, v); chk("R1 card ctrl default", v, 8'hC0);
        get(8'h02, v); chk("R1 core ctrl default", v, 8'h0C);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        pulse_start(); send(8'h32); send(8'hAA); send(8'h0B);
        pulse_start(); send(8'h32);
        fetch(v); chk("R2 first burst byte", v, 8'hAA);
        fetch(v); chk("R3 second burst byte", v, 8'h0B);
        fetch(v); chk("R3 third burst byte", v, 8'h00);
    endtask

    task automatic t_rev();
        logic [7:0] v;
        put(8'h01, 8'h55);
        pulse_start(); send(8'h01);
        fetch(v); chk("R4 revision", v, 8'h22);
        fetch(v); chk("R3 next after revision", v, 8'h0C);
    endtask

    task automatic t_clamp();
        logic [7:0] v;
        put(8'h04, 8'hFF); get(8'h04, v); chk("R5 clamp 0xFF", v, 8'h12);
        put(8'h05, 8'h31); get(8'h05, v); chk("R5 low bits 0x31", v, 8'h11);
        put(8'h04, 8'h13); get(8'h04, v); chk("R5 clamp 0x13", v, 8'h12);
        put(8'h04, 8'h12); get(8'h04, v); chk("R5 at limit", v, 8'h12);
        put(8'h05, 8'h0A); get(8'h05, v); chk("R5 below limit", v, 8'h0A);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        put(8'h1D, 8'hFF); get(8'h1D, v); chk("R6 dir mask", v, 8'h67);
        put(8'h1F, 8'hFF); get(8'h1F, v); chk("R6 out mask", v, 8'h07);
        put(8'h16, 8'hFF); get(8'h16, v); chk("R6 detect mask", v, 8'h7F);
        put(8'h3A, 8'hFF); get(8'h3A, v); chk("R6 debounce mask", v, 8'h3F);
        put(8'h15, 8'hFF); get(8'h15, v); chk("R6 R7 osc mask", v, 8'h87);
        put(8'h15, 8'h00); get(8'h15, v); chk("R7 osc good bit", v, 8'h80);
    endtask

    task automatic t_gpio();
        logic [7:0] v;
        gpio_in = 3'b101;
        get(8'h1E, v); chk("R8 all inputs", v, 8'h05);
        put(8'h1D, 8'h64);
        get(8'h1E, v); chk("R8 mixed lines", v, 8'h07);
        gpio_in = 3'b000;
        get(8'h1E, v); chk("R8 driven only", v, 8'h03);
        chk("R8 gpo port", {5'b0, gpo}, 8'h03);
    endtask

    task automatic t_backup();
        logic [7:0] v;
        put(8'h20, 8'h00); get(8'h20, v); chk("R9 backup after 0x00", v, 8'h0D);
        put(8'h20, 8'hFF); get(8'h20, v); chk("R9 backup after 0xFF", v, 8'h0D);
    endtask

    task automatic t_devoff();
        logic [7:0] v;
        put(8'h14, 8'h02); get(8'h16, v); chk("R10 bit0 clear keeps detect", v, 8'h7F);
        get(8'h14, v); chk("R10 off reg reads zero", v, 8'h00);
        put(8'h14, 8'h01);
        get(8'h16, v); chk("R10 detect restored", v, 8'h09);
        get(8'h1D, v); chk("R10 dir restored", v, 8'h07);
        get(8'h3A, v); chk("R10 debounce restored", v, 8'h05);
        get(8'h15, v); chk("R10 osc restored", v, 8'h81);
        get(8'h04, v); chk("R10 core restored", v, 8'h02);
        get(8'h20, v); chk("R10 backup restored", v, 8'h00);
        chk("R10 gpo restored", {5'b0, gpo}, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        put(8'h17, 8'hFF); get(8'h17, v); chk("R11 hole write dropped", v, 8'h00);
        put(8'h50, 8'h12); get(8'h50, v); chk("R11 high write dropped", v, 8'h00);
        get(8'h40, v); chk("R11 first address past bank", v, 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        pulse_start(); send(8'hFF); send(8'h33); send(8'h44); send(8'h55); send(8'h5A);
        get(8'h02, v); chk("R12 write after wrap", v, 8'h5A);
        pulse_start(); send(8'hFF);
        fetch(v); chk("R12 read at 0xFF", v, 8'h00);
        fetch(v); chk("R12 read at 0x00", v, 8'h00);
        fetch(v); chk("R12 read at 0x01", v, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_rev();
        t_clamp();
        t_mask();
        t_gpio();
        t_backup();
        t_devoff();
        t_unmapped();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule